// File: doc/BRIEF.md
# Flash Block Lock Controller

This block sits in front of a 256K x 16 boot-block flash array and decides, for every program or erase request, whether the array may be touched. It maps an 18-bit word address onto one of 15 erase blocks. Eight of them are small 4K-word parameter blocks and seven are 32K-word main blocks. A layout input puts the parameter blocks either at the low end or at the high end of the address space.

Each block carries its own protection state: open, locked or locked-down. Lock, unlock and lock-down commands act on the block that the current address selects. A write-protect pin decides whether a locked-down block may be reopened. A low-programming-supply flag vetoes every request. The result comes back one cycle after the request as a one-cycle grant pulse or a one-cycle error pulse. The state of the addressed block is always readable, so the surrounding logic and the bench can inspect it.

Top module: `flash_lock_guard`

## Requirements
- R1: With `param_top`=0 the blocks are indexed upward from address 0: blocks 0..7 are the 4K-word parameter blocks covering 0x00000..0x07FFF, and blocks 8..14 are the 32K-word main blocks from 0x08000 up to 0x3FFFF. `blk_idx` shows the index of `addr` combinationally.
- R2: With `param_top`=1, blocks 0..6 are the main blocks covering 0x00000..0x37FFF, and blocks 7..14 are the parameter blocks covering 0x38000..0x3FFFF. The index still rises with the address.
- R3: Every block leaves a synchronous reset (`rst_n` low at a clock edge) in the locked state, including blocks that were locked-down.
- R4: `cmd_op` encodes 00 none, 01 lock, 10 unlock and 11 lock-down. It acts at the next clock edge on the addressed block only. Lock turns an open block into a locked one, and unlock turns a locked block into an open one.
- R5: A lock-down command puts any block into the locked-down state. A locked-down block ignores lock commands. It also ignores unlock commands while `wp_n` is 0. With `wp_n`=1, an unlock opens it.
- R6: `lock_state` reports the addressed block's state combinationally, encoded as 00 open, 01 locked and 11 locked-down. The value 10 never appears.
- R7: A request (`req_valid`=1) on an open block with `vpp_low`=0 raises `grant` for exactly the one cycle after the request.
- R8: A request on a locked or locked-down block raises `err` for exactly the one cycle after the request, and `grant` stays 0.
- R9: While `vpp_low`=1, every request is answered with `err`, whatever the lock state.
- R10: `grant` and `err` are never high together, and both stay 0 in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| param_top | input | 1 | Layout select: 1 places the parameter blocks at the top |
| addr | input | 18 | Word address used for commands, requests and state readback |
| cmd_op | input | 2 | Protection command for the addressed block |
| wp_n | input | 1 | Write-protect pin; 0 keeps locked-down blocks closed |
| vpp_low | input | 1 | Programming supply below the usable level |
| req_valid | input | 1 | Program or erase request for the addressed block |
| blk_idx | output | 4 | Index of the addressed block |
| lock_state | output | 2 | Protection state of the addressed block |
| grant | output | 1 | One-cycle pulse: the request may proceed |
| err | output | 1 | One-cycle pulse: the request was refused |

## Verification
The embedded properties assume that no command or request arrives in a cycle where `rst_n` is low. They also assume that `cmd_op` and `req_valid` are not driven in the same cycle. When both are present, the request is judged on the state before the command, and the properties do not model that case. The bench changes inputs only on falling clock edges. It holds every command and request inputs idle around reset, and it issues commands and requests in separate cycles. As a result each property sees one well-defined event per cycle. A reference array of block states in the bench predicts `lock_state`, `grant` and `err` independently of the design.

// File: rtl/flg_pkg.sv
// Shared types for the flash block lock controller.
// Assumes two address tiers: main-block and parameter-block granularity.
package flg_pkg;

    typedef enum logic [1:0] {
        LK_OPEN = 2'b00,
        LK_SHUT = 2'b01,
        LK_DOWN = 2'b11
    } lock_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOCK   = 2'b01,
        OP_UNLOCK = 2'b10,
        OP_DOWN   = 2'b11
    } op_t;

endpackage

// File: rtl/flg_block_map.sv
// Translates a word address into a block index for either layout.
// Assumes the array holds 2**UPPER_W - 1 main blocks plus one main-sized
// region that is split into 2**SUB_W parameter blocks. Indices rise with
// the address in both layouts.
module flg_block_map #(
    parameter int ADDR_W   = 18,
    parameter int MAIN_AW  = 15,
    parameter int PARAM_AW = 12,
    parameter int IDX_W    = 4
) (
    input  logic              param_top,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int UPPER_W   = ADDR_W - MAIN_AW;
    localparam int SUB_W     = MAIN_AW - PARAM_AW;
    localparam int NUM_MAIN  = (1 << UPPER_W) - 1;
    localparam int NUM_PARAM = 1 << SUB_W;
    localparam int NUM_BLK   = NUM_MAIN + NUM_PARAM;

    logic [UPPER_W-1:0] upper;
    logic [SUB_W-1:0]   sub;

    assign upper = addr[ADDR_W-1:MAIN_AW];
    assign sub   = addr[MAIN_AW-1:PARAM_AW];

    // Select the index from the upper tier, then refine inside the split region.
    always_comb begin
        if (param_top) begin
            if (upper == {UPPER_W{1'b1}})
                idx = IDX_W'(NUM_MAIN) + IDX_W'(sub);
            else
                idx = IDX_W'(upper);
        end else begin
            if (upper == '0)
                idx = IDX_W'(sub);
            else
                idx = IDX_W'(NUM_PARAM - 1) + IDX_W'(upper);
        end
    end

    // Index must name an existing block.
    always_comb begin
        if (!$isunknown(addr) && !$isunknown(param_top))
            AST_IDX_IN_RANGE: assert (int'(idx) < NUM_BLK); // R1
    end

endmodule

// File: rtl/flg_lock_cell.sv
// Holds the protection state of one block and applies commands aimed at it.
// Assumes commands are only presented while out of reset.
module flg_lock_cell
    import flg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit,
    input  op_t   op,
    input  logic  wp_n,
    output lock_t state
);

    lock_t state_nx;

    // Next-state rule for one block.
    always_comb begin
        state_nx = state;
        if (hit) begin
            unique case (op)
                OP_LOCK:   if (state == LK_OPEN) state_nx = LK_SHUT;
                OP_UNLOCK: if (state == LK_SHUT || (state == LK_DOWN && wp_n))
                               state_nx = LK_OPEN;
                OP_DOWN:   state_nx = LK_DOWN;
                default:   state_nx = state;
            endcase
        end
    end

    // State register, locked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_SHUT;
        else        state <= state_nx;
    end

    AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state != lock_t'(2'b10)); // R6
    AST_DOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state) == LK_DOWN && !$past(wp_n)) |-> state == LK_DOWN); // R5
    AST_DOWN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit) && $past(op) == OP_DOWN) |-> state == LK_DOWN); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hit)) |-> state == $past(state)); // R4

endmodule

// File: rtl/flg_request_gate.sv
// Judges a program/erase request against the addressed block's state and
// the supply flag; answers one cycle later with a grant or an error pulse.
// Assumes the state presented is the one of the block being requested.
module flg_request_gate
    import flg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  lock_t cur_state,
    input  logic  vpp_low,
    output logic  grant,
    output logic  err
);

    logic allow;

    assign allow = (cur_state == LK_OPEN) && !vpp_low;

    // Register the verdict as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            err   <= 1'b0;
        end else begin
            grant <= req_valid && allow;
            err   <= req_valid && !allow;
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && err)); // R10
    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid)) |-> (!grant && !err)); // R10
    AST_SUPPLY_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(vpp_low)) |-> (err && !grant)); // R9
    AST_CLOSED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(cur_state) != LK_OPEN) |-> !grant); // R8
    AST_OPEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(cur_state) == LK_OPEN && !$past(vpp_low))
        |-> grant); // R7

endmodule

// File: rtl/flash_lock_guard.sv
// Top of the flash block lock controller: address decode, one protection
// cell per block, state readback and the request gate.
// Assumes commands and requests are not presented in the same cycle.
module flash_lock_guard
    import flg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int MAIN_AW  = 15,
    parameter int PARAM_AW = 12,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              param_top,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cmd_op,
    input  logic              wp_n,
    input  logic              vpp_low,
    input  logic              req_valid,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [1:0]        lock_state,
    output logic              grant,
    output logic              err
);
    localparam int NUM_BLK = (1 << (ADDR_W - MAIN_AW)) - 1 + (1 << (MAIN_AW - PARAM_AW));

    lock_t states [NUM_BLK];
    lock_t cur;
    op_t   op;

    assign op = op_t'(cmd_op);

    flg_block_map #(
        .ADDR_W  (ADDR_W),
        .MAIN_AW (MAIN_AW),
        .PARAM_AW(PARAM_AW),
        .IDX_W   (IDX_W)
    ) map_i (
        .param_top(param_top),
        .addr     (addr),
        .idx      (blk_idx)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_cell
        logic hit;
        assign hit = (op != OP_NONE) && (blk_idx == IDX_W'(b));
        flg_lock_cell cell_i (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (hit),
            .op   (op),
            .wp_n (wp_n),
            .state(states[b])
        );
    end

    // Read back the state of the addressed block.
    always_comb begin
        cur = LK_SHUT;
        for (int b = 0; b < NUM_BLK; b++)
            if (blk_idx == IDX_W'(b)) cur = states[b];
    end

    assign lock_state = cur;

    flg_request_gate gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .cur_state(cur),
        .vpp_low  (vpp_low),
        .grant    (grant),
        .err      (err)
    );

endmodule

// File: tb/flash_lock_guard_tb_top.sv
// Self-checking bench: address map table, then directed protection tests.
module flash_lock_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        param_top = 1'b0;
    logic [17:0] addr = '0;
    logic [1:0]  cmd_op = 2'b00;
    logic        wp_n = 1'b0;
    logic        vpp_low = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  blk_idx;
    logic [1:0]  lock_state;
    logic        grant;
    logic        err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [1:0] model [15];

    always #5 clk = ~clk;

    flash_lock_guard dut_i (
        .clk(clk), .rst_n(rst_n), .param_top(param_top), .addr(addr),
        .cmd_op(cmd_op), .wp_n(wp_n), .vpp_low(vpp_low), .req_valid(req_valid),
        .blk_idx(blk_idx), .lock_state(lock_state), .grant(grant), .err(err)
    );

    // {param_top, address, expected index}
    localparam logic [22:0] MAP_VEC [16] = '{
        {1'b0, 18'h00000, 4'd0},  {1'b0, 18'h00FFF, 4'd0},
        {1'b0, 18'h01000, 4'd1},  {1'b0, 18'h07FFF, 4'd7},
        {1'b0, 18'h08000, 4'd8},  {1'b0, 18'h0FFFF, 4'd8},
        {1'b0, 18'h10000, 4'd9},  {1'b0, 18'h3FFFF, 4'd14},
        {1'b1, 18'h00000, 4'd0},  {1'b1, 18'h07FFF, 4'd0},
        {1'b1, 18'h08000, 4'd1},  {1'b1, 18'h37FFF, 4'd6},
        {1'b1, 18'h38000, 4'd7},  {1'b1, 18'h38FFF, 4'd7},
        {1'b1, 18'h39000, 4'd8},  {1'b1, 18'h3FFFF, 4'd14}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Base address of block b in the bottom layout.
    function automatic logic [17:0] base_bot(input int b);
        return (b < 8) ? 18'(b * 4096) : 18'((b - 7) * 32768);
    endfunction

    task automatic command(input logic [17:0] a, input logic [1:0] op);
        @(negedge clk);
        addr = a; cmd_op = op;
        @(negedge clk);
        cmd_op = 2'b00;
    endtask

    task automatic request(input logic [17:0] a, input bit exp_grant, input string tag);
        @(negedge clk);
        addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(grant == exp_grant, {tag, " grant"}, int'(grant), int'(exp_grant));
        check(err == !exp_grant, {tag, " err"}, int'(err), int'(!exp_grant));
        @(negedge clk);
        check(!grant && !err, "R10 pulse ends", int'({grant, err}), 0);
    endtask

    task automatic state_is(input logic [17:0] a, input logic [1:0] exp, input string tag);
        addr = a;
        #1;
        check(lock_state == exp, tag, int'(lock_state), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // Address map table, one loop for both layouts.
        foreach (MAP_VEC[i]) begin
            param_top = MAP_VEC[i][22];
            addr = MAP_VEC[i][21:4];
            #1;
            check(blk_idx == MAP_VEC[i][3:0], MAP_VEC[i][22] ? "R2 map" : "R1 map",
                  int'(blk_idx), int'(MAP_VEC[i][3:0]));
        end
        param_top = 1'b0;

        // Reset state: every block locked, no verdict pulses.
        for (int b = 0; b < 15; b++) begin
            model[b] = 2'b01;
            state_is(base_bot(b), model[b], "R3 reset locked");
        end
        check(!grant && !err, "R10 idle after reset", int'({grant, err}), 0);

        // Locked block refuses requests.
        request(base_bot(3), 1'b0, "R8 locked refuse");

        // Unlock block 3 only.
        command(base_bot(3), 2'b10);
        state_is(base_bot(3), 2'b00, "R4 unlock");
        state_is(base_bot(4), 2'b01, "R4 neighbour untouched");
        request(base_bot(3) + 18'h00123, 1'b1, "R7 open grant");

        // Supply veto on an open block.
        vpp_low = 1'b1;
        request(base_bot(3), 1'b0, "R9 supply veto");
        vpp_low = 1'b0;

        // Relock.
        command(base_bot(3), 2'b01);
        state_is(base_bot(3), 2'b01, "R4 relock");
        request(base_bot(3), 1'b0, "R8 relocked refuse");

        // Lock-down behaviour on main block 10.
        command(base_bot(10), 2'b11);
        state_is(base_bot(10), 2'b11, "R5 lockdown");
        wp_n = 1'b0;
        command(base_bot(10), 2'b10);
        state_is(base_bot(10), 2'b11, "R5 unlock ignored wp low");
        command(base_bot(10), 2'b01);
        state_is(base_bot(10), 2'b11, "R5 lock ignored");
        request(base_bot(10), 1'b0, "R8 lockdown refuse");
        wp_n = 1'b1;
        command(base_bot(10), 2'b10);
        state_is(base_bot(10), 2'b00, "R5 unlock wp high");
        request(base_bot(10), 1'b1, "R7 reopened grant");

        // Lock-down from open, then reset clears it.
        command(base_bot(0), 2'b10);
        command(base_bot(0), 2'b11);
        state_is(base_bot(0), 2'b11, "R5 lockdown from open");
        wp_n = 1'b0;
        do_reset();
        state_is(base_bot(0), 2'b01, "R3 reset clears lockdown");
        state_is(base_bot(10), 2'b01, "R3 reset relocks open");

        // Top layout: block 14 is the last parameter block at 0x3F000.
        param_top = 1'b1;
        command(18'h3F000, 2'b10);
        state_is(18'h3F000, 2'b00, "R2 top layout unlock");
        state_is(18'h3E000, 2'b01, "R2 top neighbour locked");
        request(18'h3FFFF, 1'b1, "R7 top grant");
        vpp_low = 1'b1;
        request(18'h3F800, 1'b0, "R9 top veto");
        vpp_low = 1'b0;
        state_is(18'h3F000, 2'b00, "R6 state readback");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule